// File: doc/BRIEF.md
# Serial Flash Command Issue Controller

This block sits in front of a serial flash transfer engine and turns requests from two separate sources into a single stream of transaction descriptors. Each descriptor holds an instruction code, an instruction-options byte and a flash address. The first source is a register path. Software loads a flash address register and a command register, and the write that carries the instruction-code byte launches the command. The second source is a memory-mapped read window. A host read inside the window launches a command that takes its code and options from a separate window-control register. The flash address of that command is the read's offset within the window.

Only one transaction is in flight at a time. When a descriptor is handed to the engine, a busy status bit is set. The engine then reports either normal completion or an error termination, and both end the same way: busy clears and a sticky finished flag is set. A code write that arrives while busy is dropped whole and sets a sticky ignored-command bit. A window read that arrives while busy, or in the same cycle as a register launch, is held off until it can be granted. Read data for a window command comes back as a one-cycle valid pulse.

Top module: `flash_cmd_issue`

## Requirements
- R1: A register write at offset 1 whose byte enable 0 is set, while busy is clear, launches a command. `eng_start` pulses high for one cycle in the cycle after the write. The descriptor carries the code from bits 7:0 of that write, the options from bits 15:8 (new value if byte enable 1 is also set, otherwise the stored value), the stored address register at offset 0, and `eng_from_mm` = 0.
- R2: A write at offset 1 with byte enable 1 set and byte enable 0 clear updates only the options byte and launches nothing.
- R3: Busy (status bit 0 at offset 3) is set in the same cycle as the `eng_start` pulse. It stays set until the engine reports done or error.
- R4: On `eng_done` while busy, busy is clear in the next cycle and the finished flag (status bit 1) is set.
- R5: On `eng_err` while busy, busy clears and the finished flag is set exactly as for completion. A window command that ends this way returns `mm_rerr` = 1 together with its valid pulse.
- R6: A code write (offset 1, byte enable 0) while busy is dropped entirely. The code and options read back unchanged, no `eng_start` follows, and the sticky ignored bit (status bit 2) is set.
- R7: `mm_req` while busy is clear and no register launch is present is granted by `mm_gnt` in that cycle. The descriptor that follows carries the code and options from offset 2 (bits 7:0 and 15:8), the address `mm_addr` modulo 2^WIN_AW, and `eng_from_mm` = 1.
- R8: A register launch and `mm_req` in the same cycle: the register command is launched. `mm_gnt` stays low until busy has cleared, after which the window command is granted.
- R9: For a window command, `mm_rvalid` is high for exactly one cycle, the cycle after the engine's done or error. `mm_rdata` equals the engine's `eng_rdata` sampled at done.
- R10: Status bits 1 and 2 are cleared by writing 1 to them at offset 3. If a completion and a clear of bit 1 fall in the same cycle, bit 1 stays set.
- R11: After reset, all registers read zero, busy is clear, and `eng_start`, `mm_gnt` and `mm_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for reads and writes |
| reg_be | input | 4 | Byte enables of a register write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mm_req | input | 1 | Window read request, held until granted |
| mm_addr | input | 32 | Window read address |
| mm_gnt | output | 1 | Window read accepted this cycle |
| mm_rvalid | output | 1 | One-cycle window read response |
| mm_rerr | output | 1 | Window read ended by error termination |
| mm_rdata | output | 32 | Window read data |
| eng_start | output | 1 | Descriptor start pulse to the engine |
| eng_code | output | 8 | Instruction code of the descriptor |
| eng_opts | output | 8 | Instruction options of the descriptor |
| eng_addr | output | FA_W | Flash address of the descriptor |
| eng_from_mm | output | 1 | Descriptor came from the window path |
| eng_done | input | 1 | Engine reports normal completion |
| eng_err | input | 1 | Engine reports error termination |
| eng_rdata | input | 32 | Engine read data, valid with done |

## Verification
The bench drives a code write while a transaction is still running. A design that let it through would either start a second descriptor or overwrite the stored code, and one that dropped it silently would leave the ignored bit clear. It also lands a finished-flag clear in the same cycle as a completion, where a clear-priority flop would lose the event. A window read is made to collide with a register launch. A design with the wrong priority would grant the window read early or launch the wrong descriptor. Error terminations on both paths are checked to end exactly like completions, since a design that treated them differently would leave busy stuck or skip the finished flag.

// File: rtl/fci_pkg.sv
package fci_pkg;

  localparam int BUS_W  = 32;
  localparam int BE_W   = BUS_W / 8;
  localparam int CODE_W = 8;

  typedef enum logic [1:0] {
    RA_FADDR = 2'd0,
    RA_CMD   = 2'd1,
    RA_MCTL  = 2'd2,
    RA_STAT  = 2'd3
  } reg_sel_e;

  localparam int ST_BUSY = 0;
  localparam int ST_FIN  = 1;
  localparam int ST_IGN  = 2;

  // byte-enable merge of a full bus word
  function automatic logic [BUS_W-1:0] merge_be(input logic [BUS_W-1:0] old_v,
                                               input logic [BUS_W-1:0] new_v,
                                               input logic [BE_W-1:0]  be);
    logic [BUS_W-1:0] r;
    r = old_v;
    for (int i = 0; i < BE_W; i++) begin
      if (be[i]) r[8*i +: 8] = new_v[8*i +: 8];
    end
    return r;
  endfunction

  // pick one byte lane of a bus word
  function automatic logic [CODE_W-1:0] lane(input logic [BUS_W-1:0] w, input int idx);
    return w[8*idx +: 8];
  endfunction

endpackage

// File: rtl/fci_regs.sv
module fci_regs
  import fci_pkg::*;
#(
  parameter int FA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [BE_W-1:0]   be,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              busy,
  input  logic              fin_set,
  output logic [BUS_W-1:0]  rdata,
  output logic [FA_W-1:0]   faddr_q,
  output logic [CODE_W-1:0] code_nxt,
  output logic [CODE_W-1:0] opts_nxt,
  output logic [CODE_W-1:0] mcode_q,
  output logic [CODE_W-1:0] mopts_q,
  output logic              launch_reg,
  output logic              code_blocked
);

  logic [CODE_W-1:0] code_q, opts_q;
  logic              fin_q, ign_q;
  logic              hit_faddr, hit_cmd, hit_mctl, hit_stat;
  logic              code_wr, cmd_accept;
  logic              clr_fin, clr_ign;
  logic [BUS_W-1:0]  mctl_mg;
  logic [FA_W-1:0]   faddr_mg;

  // per-bit byte-enable merge sized to the flash address
  function automatic logic [FA_W-1:0] addr_merge(input logic [FA_W-1:0]  old_v,
                                                input logic [BUS_W-1:0] new_v,
                                                input logic [BE_W-1:0]  bes);
    logic [FA_W-1:0] r;
    r = old_v;
    for (int b = 0; b < FA_W; b++) begin
      if (bes[b/8]) r[b] = new_v[b];
    end
    return r;
  endfunction

  assign hit_faddr = wr && (addr == RA_FADDR);
  assign hit_cmd   = wr && (addr == RA_CMD);
  assign hit_mctl  = wr && (addr == RA_MCTL);
  assign hit_stat  = wr && (addr == RA_STAT);

  // the code-byte write is the launch event
  assign code_wr      = hit_cmd && be[0];
  assign code_blocked = code_wr && busy;
  assign launch_reg   = code_wr && !busy;
  assign cmd_accept   = hit_cmd && !code_blocked;

  // values the descriptor is built from when this write launches
  assign code_nxt = be[0] ? lane(wdata, 0) : code_q;
  assign opts_nxt = be[1] ? lane(wdata, 1) : opts_q;

  assign clr_fin  = hit_stat && be[0] && wdata[ST_FIN];
  assign clr_ign  = hit_stat && be[0] && wdata[ST_IGN];

  assign mctl_mg  = merge_be({{(BUS_W-2*CODE_W){1'b0}}, mopts_q, mcode_q}, wdata, be);
  assign faddr_mg = addr_merge(faddr_q, wdata, be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      faddr_q <= '0;
      code_q  <= '0;
      opts_q  <= '0;
      mcode_q <= '0;
      mopts_q <= '0;
    end else begin
      if (hit_faddr)  faddr_q <= faddr_mg;
      if (cmd_accept) begin
        code_q <= code_nxt;
        opts_q <= opts_nxt;
      end
      if (hit_mctl) begin
        mcode_q <= mctl_mg[CODE_W-1:0];
        mopts_q <= mctl_mg[2*CODE_W-1:CODE_W];
      end
    end
  end

  // sticky flags: a set event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_q <= 1'b0;
      ign_q <= 1'b0;
    end else begin
      if (fin_set)           fin_q <= 1'b1;
      else if (clr_fin)      fin_q <= 1'b0;
      if (code_blocked)      ign_q <= 1'b1;
      else if (clr_ign)      ign_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_FADDR: rdata[FA_W-1:0] = faddr_q;
      RA_CMD:   rdata[2*CODE_W-1:0] = {opts_q, code_q};
      RA_MCTL:  rdata[2*CODE_W-1:0] = {mopts_q, mcode_q};
      default: begin
        rdata[ST_BUSY] = busy;
        rdata[ST_FIN]  = fin_q;
        rdata[ST_IGN]  = ign_q;
      end
    endcase
  end

  assert_blocked_code_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    code_blocked |=> ($stable(code_q) && $stable(opts_q) && ign_q));

  assert_fin_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fin_set |=> fin_q);

  assert_opts_only_no_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cmd && !be[0]) |-> !launch_reg);

endmodule

// File: rtl/fci_arb.sv
module fci_arb (
  input  logic launch_reg,
  input  logic mm_req,
  input  logic busy,
  output logic take_reg,
  output logic take_mm,
  output logic mm_stall
);

  // register path has priority; a window read waits for idle
  assign take_reg = launch_reg;
  assign mm_stall = mm_req && (busy || launch_reg);
  assign take_mm  = mm_req && !mm_stall;

endmodule

// File: rtl/fci_seq.sv
module fci_seq
  import fci_pkg::*;
#(
  parameter int FA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_reg,
  input  logic              take_mm,
  input  logic [CODE_W-1:0] reg_code,
  input  logic [CODE_W-1:0] reg_opts,
  input  logic [FA_W-1:0]   reg_faddr,
  input  logic [CODE_W-1:0] mm_code,
  input  logic [CODE_W-1:0] mm_opts,
  input  logic [FA_W-1:0]   mm_off,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic [BUS_W-1:0]  eng_rdata,
  output logic              busy,
  output logic              fin_set,
  output logic              eng_start,
  output logic [CODE_W-1:0] eng_code,
  output logic [CODE_W-1:0] eng_opts,
  output logic [FA_W-1:0]   eng_addr,
  output logic              eng_from_mm,
  output logic              mm_rvalid,
  output logic              mm_rerr,
  output logic [BUS_W-1:0]  mm_rdata
);

  logic launch_any;

  assign launch_any = take_reg || take_mm;
  // completion and error termination end a transaction the same way
  assign fin_set    = busy && (eng_done || eng_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      eng_start   <= 1'b0;
      eng_code    <= '0;
      eng_opts    <= '0;
      eng_addr    <= '0;
      eng_from_mm <= 1'b0;
    end else begin
      eng_start <= launch_any;
      if (launch_any) begin
        busy        <= 1'b1;
        eng_from_mm <= take_mm;
        eng_code    <= take_reg ? reg_code  : mm_code;
        eng_opts    <= take_reg ? reg_opts  : mm_opts;
        eng_addr    <= take_reg ? reg_faddr : mm_off;
      end else if (fin_set) begin
        busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mm_rvalid <= 1'b0;
      mm_rerr   <= 1'b0;
      mm_rdata  <= '0;
    end else begin
      mm_rvalid <= fin_set && eng_from_mm;
      mm_rerr   <= fin_set && eng_from_mm && eng_err;
      if (fin_set && eng_from_mm) mm_rdata <= eng_rdata;
    end
  end

  assert_start_with_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy);

  assert_busy_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin_set) |=> busy);

  assert_end_clears_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fin_set |=> !busy);

  assert_no_launch_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    launch_any |-> !busy);

  assert_single_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_reg && take_mm));

  assert_rvalid_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mm_rvalid |-> (!busy && $past(busy)));

  assert_rvalid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mm_rvalid |=> !mm_rvalid);

endmodule

// File: rtl/flash_cmd_issue.sv
module flash_cmd_issue
  import fci_pkg::*;
#(
  parameter int FA_W   = 24,
  parameter int WIN_AW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              mm_req,
  input  logic [31:0]       mm_addr,
  output logic              mm_gnt,
  output logic              mm_rvalid,
  output logic              mm_rerr,
  output logic [31:0]       mm_rdata,
  output logic              eng_start,
  output logic [7:0]        eng_code,
  output logic [7:0]        eng_opts,
  output logic [FA_W-1:0]   eng_addr,
  output logic              eng_from_mm,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic [31:0]       eng_rdata
);

  localparam logic [BUS_W-1:0] WIN_MASK = (BUS_W'(1) << WIN_AW) - BUS_W'(1);

  // flash address of a window read: its offset inside the window
  function automatic logic [FA_W-1:0] window_offset(input logic [BUS_W-1:0] a);
    logic [BUS_W-1:0] m;
    m = a & WIN_MASK;
    return m[FA_W-1:0];
  endfunction

  logic              busy, fin_set;
  logic              launch_reg, code_blocked;
  logic              take_reg, take_mm, mm_stall;
  logic [FA_W-1:0]   faddr_q, mm_off;
  logic [CODE_W-1:0] code_nxt, opts_nxt, mcode_q, mopts_q;

  assign mm_off = window_offset(mm_addr);
  assign mm_gnt = take_mm;

  fci_regs #(.FA_W(FA_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr           (reg_wr),
    .addr         (reg_addr),
    .be           (reg_be),
    .wdata        (reg_wdata),
    .busy         (busy),
    .fin_set      (fin_set),
    .rdata        (reg_rdata),
    .faddr_q      (faddr_q),
    .code_nxt     (code_nxt),
    .opts_nxt     (opts_nxt),
    .mcode_q      (mcode_q),
    .mopts_q      (mopts_q),
    .launch_reg   (launch_reg),
    .code_blocked (code_blocked)
  );

  fci_arb u_arb (
    .launch_reg (launch_reg),
    .mm_req     (mm_req),
    .busy       (busy),
    .take_reg   (take_reg),
    .take_mm    (take_mm),
    .mm_stall   (mm_stall)
  );

  fci_seq #(.FA_W(FA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_reg    (take_reg),
    .take_mm     (take_mm),
    .reg_code    (code_nxt),
    .reg_opts    (opts_nxt),
    .reg_faddr   (faddr_q),
    .mm_code     (mcode_q),
    .mm_opts     (mopts_q),
    .mm_off      (mm_off),
    .eng_done    (eng_done),
    .eng_err     (eng_err),
    .eng_rdata   (eng_rdata),
    .busy        (busy),
    .fin_set     (fin_set),
    .eng_start   (eng_start),
    .eng_code    (eng_code),
    .eng_opts    (eng_opts),
    .eng_addr    (eng_addr),
    .eng_from_mm (eng_from_mm),
    .mm_rvalid   (mm_rvalid),
    .mm_rerr     (mm_rerr),
    .mm_rdata    (mm_rdata)
  );

  assert_stall_blocks_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mm_stall |-> !mm_gnt);

  assert_blocked_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_blocked && !mm_gnt) |=> !eng_start);

  assert_grant_starts_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mm_gnt |=> (eng_start && eng_from_mm));

endmodule

// File: tb/flash_cmd_issue_tb.sv
module flash_cmd_issue_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mm_req;
  logic [31:0] mm_addr;
  logic        mm_gnt, mm_rvalid, mm_rerr;
  logic [31:0] mm_rdata;
  logic        eng_start, eng_from_mm;
  logic [7:0]  eng_code, eng_opts;
  logic [23:0] eng_addr;
  logic        eng_done, eng_err;
  logic [31:0] eng_rdata;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_issue #(.FA_W(24), .WIN_AW(24)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mm_req(mm_req), .mm_addr(mm_addr),
    .mm_gnt(mm_gnt), .mm_rvalid(mm_rvalid), .mm_rerr(mm_rerr), .mm_rdata(mm_rdata),
    .eng_start(eng_start), .eng_code(eng_code), .eng_opts(eng_opts), .eng_addr(eng_addr),
    .eng_from_mm(eng_from_mm), .eng_done(eng_done), .eng_err(eng_err), .eng_rdata(eng_rdata)
  );

  // engine stub: fixed latency, or driven by hand
  logic       manual, man_done, man_err, err_sel;
  logic [3:0] lat, cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= 4'd0;
    else if (eng_start) cnt <= lat;
    else if (cnt != 4'd0) cnt <= cnt - 4'd1;
  end
  assign eng_done  = manual ? man_done : (cnt == 4'd1 && !err_sel);
  assign eng_err   = manual ? man_err  : (cnt == 4'd1 &&  err_sel);
  assign eng_rdata = {8'hD0, eng_addr} ^ 32'h00FF00FF;

  function automatic logic [31:0] exp_rdata(input logic [23:0] a);
    return {8'hD0, a[23:16] ^ 8'hFF, a[15:8], a[7:0] ^ 8'hFF};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 4'h0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && u_dut.reg_rdata !== 32'hx; i++) begin
      logic [31:0] s;
      rd(2'd3, s);
      if (!s[0]) break;
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic        mm;
    logic        split;
    logic [7:0]  code;
    logic [7:0]  opts;
    logic [23:0] addr;
    logic        err;
    logic [3:0]  lat;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, 8'h03, 8'h10, 24'h000100, 1'b0, 4'd2},
    '{1'b0, 1'b1, 8'h0B, 8'h81, 24'hABCDEF, 1'b0, 4'd5},
    '{1'b1, 1'b0, 8'h6B, 8'h44, 24'h123456, 1'b0, 4'd3},
    '{1'b0, 1'b0, 8'h02, 8'hFF, 24'hFFFFFF, 1'b1, 4'd1},
    '{1'b1, 1'b0, 8'hEB, 8'h07, 24'h000000, 1'b1, 4'd4},
    '{1'b1, 1'b0, 8'h0C, 8'h5A, 24'hFFFFFC, 1'b0, 4'd1}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_be = 4'h0; reg_wdata = '0;
    mm_req = 1'b0; mm_addr = '0; manual = 1'b0; man_done = 1'b0; man_err = 1'b0;
    err_sel = 1'b0; lat = 4'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(2'd3, s); chk(s == 32'h0, "R11 status", 64'(s), 64'h0);
    rd(2'd1, s); chk(s == 32'h0, "R11 cmd reg", 64'(s), 64'h0);
    rd(2'd0, s); chk(s == 32'h0, "R11 addr reg", 64'(s), 64'h0);
    chk(!eng_start && !mm_gnt && !mm_rvalid, "R11 outputs idle",
        64'({eng_start, mm_gnt, mm_rvalid}), 64'h0);

    // R2 options-only write does not launch
    wr(2'd1, 4'b0010, 32'h0000_5A00);
    chk(!eng_start, "R2 no start on options write", 64'(eng_start), 64'h0);
    rd(2'd1, s); chk(s[15:0] == 16'h5A00, "R2 options stored", 64'(s), 64'h5A00);

    // vector table: both paths, completion and error
    foreach (VECS[k]) begin
      vec_t v;
      v = VECS[k];
      lat = v.lat; err_sel = v.err;
      if (!v.mm) begin
        wr(2'd0, 4'hF, {8'h00, v.addr});
        if (v.split) begin
          wr(2'd1, 4'b0010, {16'h0, v.opts, 8'h00});
          wr(2'd1, 4'b0001, {16'h0, 8'h00, v.code});
        end else begin
          wr(2'd1, 4'b0011, {16'h0, v.opts, v.code});
        end
        chk(eng_start && eng_code == v.code && eng_opts == v.opts && eng_addr == v.addr && !eng_from_mm,
            "R1 register descriptor", {eng_start, eng_from_mm, 6'h0, eng_code, eng_opts, 8'h0, eng_addr},
            {1'b1, 1'b0, 6'h0, v.code, v.opts, 8'h0, v.addr});
      end else begin
        wr(2'd2, 4'b0011, {16'h0, v.opts, v.code});
        mm_req = 1'b1; mm_addr = {8'h3C, v.addr};
        #1;
        chk(mm_gnt == 1'b1, "R7 window grant when idle", 64'(mm_gnt), 64'h1);
        @(negedge clk);
        mm_req = 1'b0;
        chk(eng_start && eng_code == v.code && eng_opts == v.opts && eng_addr == v.addr && eng_from_mm,
            "R7 window descriptor", {eng_start, eng_from_mm, 6'h0, eng_code, eng_opts, 8'h0, eng_addr},
            {1'b1, 1'b1, 6'h0, v.code, v.opts, 8'h0, v.addr});
      end
      rd(2'd3, s); chk(s[0] == 1'b1, "R3 busy with start", 64'(s), 64'h1);
      for (int i = 0; i < 30; i++) begin
        rd(2'd3, s);
        if (!s[0]) break;
        @(negedge clk);
      end
      chk(s[1:0] == 2'b10, v.err ? "R5 error ends like completion" : "R4 completion sets flag",
          64'(s), 64'h2);
      if (v.mm) begin
        chk(mm_rvalid && mm_rerr == v.err && (v.err || mm_rdata == exp_rdata(v.addr)),
            "R9 window response", {mm_rvalid, mm_rerr, mm_rdata}, {1'b1, v.err, exp_rdata(v.addr)});
        @(negedge clk);
        chk(!mm_rvalid, "R9 valid is one cycle", 64'(mm_rvalid), 64'h0);
      end
      wr(2'd3, 4'h1, 32'h2);
      rd(2'd3, s); chk(s[1] == 1'b0, "R10 write-one clears flag", 64'(s), 64'h0);
    end

    // R6 code write while busy is ignored
    manual = 1'b1;
    wr(2'd1, 4'b0011, 32'h0000_2211);
    wr(2'd1, 4'b0011, 32'h0000_4433);
    chk(!eng_start, "R6 no start while busy", 64'(eng_start), 64'h0);
    rd(2'd1, s); chk(s[15:0] == 16'h2211, "R6 code kept", 64'(s), 64'h2211);
    rd(2'd3, s); chk(s[2:0] == 3'b101, "R6 ignored bit set", 64'(s), 64'h5);

    // R10 completion and clear in the same cycle: flag stays set
    man_done = 1'b1;
    wr(2'd3, 4'h1, 32'h2);
    man_done = 1'b0;
    rd(2'd3, s); chk(s[2:0] == 3'b110, "R10 set wins over clear", 64'(s), 64'h6);
    wr(2'd3, 4'h1, 32'h6);
    rd(2'd3, s); chk(s[2:0] == 3'b000, "R10 both sticky bits cleared", 64'(s), 64'h0);

    // R8 same-cycle collision: register path first, window read stalled
    wr(2'd2, 4'b0011, 32'h0000_7766);
    mm_req = 1'b1; mm_addr = 32'h5500_0040;
    reg_wr = 1'b1; reg_addr = 2'd1; reg_be = 4'b0001; reg_wdata = 32'h0000_0099;
    #1;
    chk(!mm_gnt, "R8 no grant during register launch", 64'(mm_gnt), 64'h0);
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 4'h0;
    chk(eng_start && !eng_from_mm && eng_code == 8'h99, "R8 register path wins",
        {eng_start, eng_from_mm, eng_code}, {1'b1, 1'b0, 8'h99});
    @(negedge clk);
    chk(!mm_gnt, "R8 window stalled while busy", 64'(mm_gnt), 64'h0);
    man_done = 1'b1;
    @(negedge clk);
    man_done = 1'b0;
    #1;
    chk(mm_gnt, "R8 window granted once idle", 64'(mm_gnt), 64'h1);
    @(negedge clk);
    mm_req = 1'b0;
    chk(eng_start && eng_from_mm && eng_addr == 24'h000040 && eng_code == 8'h66 && eng_opts == 8'h77,
        "R7 offset and window control used", {eng_from_mm, eng_code, eng_opts, eng_addr},
        {1'b1, 8'h66, 8'h77, 24'h000040});
    man_err = 1'b1;
    @(negedge clk);
    man_err = 1'b0;
    chk(mm_rvalid && mm_rerr, "R5 window error response", {mm_rvalid, mm_rerr}, 2'b11);
    rd(2'd3, s); chk(s[1:0] == 2'b10, "R5 error clears busy", 64'(s), 64'h2);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule